// File: doc/BRIEF.md
# Pseudo-static memory write sequencer

This block turns a single-cycle write request on a synchronous interface into a correctly timed write cycle on an asynchronous 16-bit pseudo-static memory with 2M words. The requester presents a word address, write data and two byte-lane enables together with a request strobe. The block captures them, drives the memory pins through a setup phase, a write pulse and a recovery phase, and then reports completion with a one-cycle done pulse.

Every analog timing minimum is a nanosecond parameter. Each is turned into a whole number of system-clock cycles by rounding up against the clock period parameter. The write pulse is long enough for both the write-pulse minimum and the lane-overlap minimum. The recovery phase is long enough for both the chip-enable high minimum and the remainder of the full cycle-time minimum. Output enable is never asserted, so the memory cannot start a read by accident when the address or chip enable changes.

Top module: `psram_write_seq`

## Requirements
- R1: After reset, ready is 1 and done is 0. The chip-enable, write-enable, lower-lane and upper-lane strobes are all high (inactive), and the data bus enable is 0.
- R2: A request is taken only when ready is 1. A request raised while a write is in progress starts no further write and does not change the captured address or data.
- R3: On the clock edge that takes a request, ready falls, chip enable falls and the captured address and data appear with the bus enable set. Write enable and both lanes stay high for SETUP_CYC = max(1, ceil(ADDR_LEAD_NS/CLK_NS)) cycles.
- R4: Write enable is low for exactly PULSE_CYC = max(ceil(PULSE_NS/CLK_NS), ceil(OVERLAP_NS/CLK_NS)) cycles. During those cycles the lower lane strobe is low exactly when enable bit 0 is 1, and the upper lane strobe is low exactly when enable bit 1 is 1. With enable 00 neither lane falls, but write enable still pulses.
- R5: Write enable, both lanes and chip enable all return high on the same edge. The data bus stays driven for one more cycle and is then released.
- R6: The recovery phase lasts RECOV_CYC = max(ceil(HIGH_NS/CLK_NS), ceil(CYCLE_NS/CLK_NS) − SETUP_CYC − PULSE_CYC) cycles. Ready therefore returns SETUP_CYC + PULSE_CYC + RECOV_CYC cycles after the taking edge.
- R7: Done is high for exactly one cycle, on the cycle in which ready returns to 1.
- R8: Output enable is high in every cycle.
- R9: Chip enable never stays low for LOW_MAX_NS or longer. While it is low, the address and data outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Write request strobe |
| req_addr | input | 21 | Word address of the write |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| ready | output | 1 | High when a request can be taken |
| done | output | 1 | One-cycle pulse when a write completes |
| mem_addr | output | 21 | Memory address pins |
| mem_dq_o | output | 16 | Memory data out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |

## Verification
The bench sweeps every lane-enable pattern against several address and data patterns and compares every pin in every cycle of each write against phase lengths it derives itself from the nanosecond values. A phase count that is off by one shows up as a write-enable pulse or recovery phase one cycle too short or too long. Swapping the lanes or inverting the enable polarity makes the wrong strobe fall. Releasing the bus on the write-enable rising edge makes the data vanish one cycle early. Stray requests are raised during busy cycles; a design that takes them would change the address pins or produce an extra done.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } wr_phase_e;

    typedef struct packed {
        wr_phase_e phase;
        logic      ce1_n;
        logic      we_n;
        logic      oe_n;
        logic      lb_n;
        logic      ub_n;
        logic      dq_oe;
        logic      ready;
        logic      done;
    } wr_ctl_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_wr_timer.sv
module psram_wr_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_wr_hold.sv
module psram_wr_hold #(
    parameter int AW = 21,
    parameter int DW = 16,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [BW-1:0] be_in,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] data_out,
    output logic [BW-1:0] be_out
);
    logic [AW-1:0] addr_d, addr_q;
    logic [DW-1:0] data_d, data_q;
    logic [BW-1:0] be_d, be_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        be_d   = be_q;
        if (capture) begin
            addr_d = addr_in;
            data_d = data_in;
            be_d   = be_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
            be_q   <= be_d;
        end
    end

    assign addr_out = addr_q;
    assign data_out = data_q;
    assign be_out   = be_q;

endmodule

// File: rtl/psram_write_seq.sv
module psram_write_seq
    import psram_wr_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int DATA_W       = 16,
    parameter int CLK_NS       = 5,
    parameter int ADDR_LEAD_NS = 0,
    parameter int PULSE_NS     = 40,
    parameter int OVERLAP_NS   = 30,
    parameter int HIGH_NS      = 12,
    parameter int CYCLE_NS     = 65,
    parameter int LOW_MAX_NS   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    output logic              ready,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_ce1_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);
    localparam int SETUP_CYC   = imax(1, ceil_div(ADDR_LEAD_NS, CLK_NS));
    localparam int PULSE_CYC   = imax(ceil_div(PULSE_NS, CLK_NS), ceil_div(OVERLAP_NS, CLK_NS));
    localparam int RECOV_CYC   = imax(imax(1, ceil_div(HIGH_NS, CLK_NS)),
                                      ceil_div(CYCLE_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
    localparam int LOW_MAX_CYC = LOW_MAX_NS / CLK_NS;
    localparam int LONGEST     = imax(SETUP_CYC, imax(PULSE_CYC, RECOV_CYC));
    localparam int CW          = $clog2(LONGEST + 1);
    localparam int RW          = $clog2(LOW_MAX_CYC + 2);

    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] RECOV_LD = CW'(RECOV_CYC - 1);

    wr_ctl_t       ctl_d, ctl_q;
    logic          take;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic [1:0]    be_held;

    assign take = req && ctl_q.ready;

    psram_wr_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    psram_wr_hold #(.AW(ADDR_W), .DW(DATA_W), .BW(2)) i_hold (
        .clk      (clk),
        .rst      (rst),
        .capture  (take),
        .addr_in  (req_addr),
        .data_in  (req_data),
        .be_in    (req_be),
        .addr_out (mem_addr),
        .data_out (mem_dq_o),
        .be_out   (be_held)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.oe_n = 1'b1;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (take) begin
                    ctl_d.phase = PH_SETUP;
                    ctl_d.ready = 1'b0;
                    ctl_d.ce1_n = 1'b0;
                    ctl_d.dq_oe = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = SETUP_LD;
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    ctl_d.phase = PH_PULSE;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.lb_n  = ~be_held[0];
                    ctl_d.ub_n  = ~be_held[1];
                    tmr_load    = 1'b1;
                    tmr_val     = PULSE_LD;
                end
            end
            PH_PULSE: begin
                if (tmr_expired) begin
                    ctl_d.phase = PH_RECOV;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.lb_n  = 1'b1;
                    ctl_d.ub_n  = 1'b1;
                    ctl_d.ce1_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = RECOV_LD;
                end
            end
            PH_RECOV: begin
                ctl_d.dq_oe = 1'b0;
                if (tmr_expired) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.ready = 1'b1;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.ce1_n <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.lb_n  <= 1'b1;
            ctl_q.ub_n  <= 1'b1;
            ctl_q.dq_oe <= 1'b0;
            ctl_q.ready <= 1'b1;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready     = ctl_q.ready;
    assign done      = ctl_q.done;
    assign mem_ce1_n = ctl_q.ce1_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_lb_n  = ctl_q.lb_n;
    assign mem_ub_n  = ctl_q.ub_n;
    assign mem_dq_oe = ctl_q.dq_oe;

    // Run-length counters that exist only for the properties below
    logic [CW:0] we_run_q;
    logic [RW:0] ce_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run_q <= '0;
            ce_run_q <= '0;
        end else begin
            we_run_q <= mem_we_n  ? '0 : we_run_q + 1'b1;
            ce_run_q <= mem_ce1_n ? '0 : ce_run_q + 1'b1;
        end
    end

    p_we_len_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run_q == (CW+1)'(PULSE_CYC)));

    p_we_in_ce_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce1_n);

    p_bus_in_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    p_ce_limit_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_ce1_n |-> (ce_run_q < (RW+1)'(LOW_MAX_CYC)));

    p_addr_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

    p_take_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

    p_done_ready_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (ready && $past(!ready)));

    p_no_read_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce1_n) |-> mem_oe_n);

endmodule

// File: tb/test_psram_write_seq.sv
module test_psram_write_seq;
    localparam int CLKP = 5;
    // Phase lengths derived from the nanosecond minimums at a 5 ns clock
    localparam int S_CYC = 1;                         // max(1, ceil(0/5))
    localparam int P_CYC = (40 + CLKP - 1) / CLKP;     // 8, overlap 30ns needs 6
    localparam int R_MIN = (12 + CLKP - 1) / CLKP;     // 3
    localparam int R_FIT = (65 + CLKP - 1) / CLKP - S_CYC - P_CYC; // 4
    localparam int R_CYC = (R_FIT > R_MIN) ? R_FIT : R_MIN;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_be = '0;
    logic        ready, done, mem_dq_oe, mem_ce1_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [20:0] mem_addr;
    logic [15:0] mem_dq_o;

    int total = 0;
    int bad = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    psram_write_seq i_psram_write_seq (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
        .req_be(req_be), .ready(ready), .done(done), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_ce1_n(mem_ce1_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    always @(posedge clk) if (!rst && done) done_seen++;

    task automatic chk(input string req_tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    task automatic write_one(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be,
                             input bit stray);
        int n;
        @(negedge clk);
        chk("R2", "ready before request", int'(ready), 1);
        req = 1'b1; req_addr = a; req_data = d; req_be = be;
        @(posedge clk);
        n = done_seen;
        for (int k = 1; k <= S_CYC + P_CYC + R_CYC + 1; k++) begin
            @(negedge clk);
            if (stray && k >= 2 && k <= S_CYC + P_CYC) begin
                req = 1'b1; req_addr = ~a; req_data = ~d; req_be = ~be;
            end else begin
                req = 1'b0;
            end
            chk("R8", "oe_n", int'(mem_oe_n), 1);
            if (k <= S_CYC + P_CYC) begin
                chk("R3", "ce1_n low", int'(mem_ce1_n), 0);
                chk("R9", "addr while ce low", int'(mem_addr), int'(a));
                chk("R9", "data while ce low", int'(mem_dq_o), int'(d));
                chk("R3", "bus driven", int'(mem_dq_oe), 1);
                chk("R2", "ready low while busy", int'(ready), 0);
            end
            if (k <= S_CYC) begin
                chk("R3", "we_n in setup", int'(mem_we_n), 1);
                chk("R3", "lanes in setup", int'({mem_ub_n, mem_lb_n}), 3);
            end else if (k <= S_CYC + P_CYC) begin
                chk("R4", "we_n in pulse", int'(mem_we_n), 0);
                chk("R4", "lb_n", int'(mem_lb_n), int'(!be[0]));
                chk("R4", "ub_n", int'(mem_ub_n), int'(!be[1]));
            end else if (k == S_CYC + P_CYC + 1) begin
                chk("R5", "strobes high", int'({mem_ce1_n, mem_we_n, mem_ub_n, mem_lb_n}), 15);
                chk("R5", "data held one cycle", int'(mem_dq_oe), 1);
                chk("R5", "data value held", int'(mem_dq_o), int'(d));
            end else if (k <= S_CYC + P_CYC + R_CYC) begin
                chk("R5", "bus released", int'(mem_dq_oe), 0);
                chk("R6", "ready low in recovery", int'(ready), 0);
                chk("R6", "ce1_n high in recovery", int'(mem_ce1_n), 1);
                chk("R7", "no early done", int'(done), 0);
            end else begin
                chk("R6", "ready returns", int'(ready), 1);
                chk("R7", "done pulse", int'(done), 1);
            end
        end
        @(negedge clk);
        chk("R7", "done one cycle", int'(done), 0);
        chk("R2", "one write per request", done_seen - n, 1);
        chk("R2", "idle after write", int'(mem_ce1_n), 1);
        chk("R2", "addr not overwritten", int'(mem_addr), int'(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "done", int'(done), 0);
        chk("R1", "strobes", int'({mem_ce1_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}), 31);
        chk("R1", "bus enable", int'(mem_dq_oe), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", int'({ready, mem_ce1_n, mem_dq_oe}), 6);
        for (int be = 0; be < 4; be++) begin
            for (int p = 0; p < 6; p++) begin
                write_one(21'(32'h1F_FFFF >> (p * 3)) ^ 21'(be * 7),
                          16'(16'hA5C3 * (p + 1)) ^ 16'(be << 12),
                          2'(be), (p % 2) == 1);
            end
        end
        write_one(21'h1F_FFFF, 16'hFFFF, 2'b11, 1'b1);
        write_one(21'h00_0000, 16'h0000, 2'b00, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule